// File: doc/BRIEF.md
# SPI Serial Clock Generator with Dual Divider Modes

This block derives the serial clock of an SPI controller from the module clock. A single clock-control word carries two divisor fields. One is an 8-bit linear field that gives a serial period of 2 × (N + 1) module cycles. The other is a 4-bit exponent field that gives a period of 2^(E + 1) module cycles. A select bit in the same word decides which field is used. Software computes the field values. The block only decodes the word and counts.

While the transfer engine holds `burst_on` high, the block toggles `sck` at the programmed half period. For every edge it also raises one of two single-cycle strobes, `launch_stb` or `sample_stb`, so the engine knows whether to shift data out or capture data in. When no burst is running, `sck` rests at the idle level chosen by `idle_high`. The divisor and the phase choice are captured only while the block is idle. A setting written in the middle of a burst therefore cannot cut a clock phase short.

Top module: `spi_sck_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `sck`, `launch_stb` and `sample_stb` are all 0.
- R2: In every cycle that follows a cycle with `burst_on` low, `sck` equals the `idle_high` value of that earlier cycle, and both strobes are 0.
- R3: When bit 12 of `clk_ctl` is 1 (linear mode), each `sck` level lasts `clk_ctl[7:0]` + 1 module cycles. The first toggle appears that many cycles after the first cycle in which `burst_on` is seen high.
- R4: In linear mode with `clk_ctl[7:0]` = 0, `sck` toggles on every module cycle of a burst, which gives MOD_CLK/2 at a 50% duty cycle.
- R5: When bit 12 of `clk_ctl` is 0 (exponential mode), each `sck` level lasts 2^`clk_ctl[11:8]` module cycles.
- R6: `clk_ctl` and `late_phase` are captured in every cycle in which `burst_on` is low. Changes to them while `burst_on` is high have no effect on `sck` or the strobes until the next idle period.
- R7: With `late_phase` = 0, the 1st, 3rd, 5th and later odd-numbered edges of a burst assert `sample_stb`, and the even-numbered edges assert `launch_stb`. With `late_phase` = 1 the two strobes swap roles.
- R8: Each strobe is high for exactly one module cycle, in the same cycle in which `sck` shows its new level. `sck` never changes during a burst without one of the strobes.
- R9: When `burst_on` drops, even partway through a half period, `sck` returns to idle in the next cycle. The next burst restarts counting from the beginning of a half period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_ctl | input | 13 | Clock-control word: [7:0] linear divisor, [11:8] exponent, [12] mode select (1 = linear) |
| idle_high | input | 1 | Idle level of `sck` (clock polarity) |
| late_phase | input | 1 | 0: odd-numbered edges sample; 1: odd-numbered edges launch |
| burst_on | input | 1 | High while the transfer engine runs a burst |
| sck | output | 1 | Serial clock |
| launch_stb | output | 1 | One-cycle strobe on edges where data is launched |
| sample_stb | output | 1 | One-cycle strobe on edges where data is sampled |

## Verification
Linear divisors of 0, 3 and 255 separate the fastest case, where the counter wraps every cycle, from mid-range and full-field half periods. Exponents of 0, 2 and 10 show that the exponent is used as a power of two rather than as a plain count. Runs with all four combinations of polarity and phase separate the idle level from the order of the strobes. Two further sequences show which settings are taken and which are ignored: one rewrites the control word, the polarity and the phase in the middle of a burst, and the other drops `burst_on` partway through a half period.

// File: rtl/spi_sck_pkg.sv
package spi_sck_pkg;
  // Divider scheme encoded by the mode-select bit of the control word.
  typedef enum logic {
    DIV_EXP = 1'b0,
    DIV_LIN = 1'b1
  } div_mode_e;

  // Width of a half-period counter able to hold both divisor schemes.
  function automatic int unsigned half_cnt_width(input int unsigned lin_w, input int unsigned exp_w);
    int unsigned exp_need;
    exp_need = (1 << exp_w) - 1;
    return (lin_w > exp_need) ? lin_w : exp_need;
  endfunction
endpackage

// File: rtl/spi_sck_cfg.sv
module spi_sck_cfg
  import spi_sck_pkg::*;
#(
  parameter int unsigned LIN_W = 8,
  parameter int unsigned EXP_W = 4,
  parameter int unsigned CNT_W = 15
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   hold,
  input  logic [LIN_W+EXP_W:0]   ctl,
  output logic [CNT_W-1:0]       half_m1
);
  localparam int unsigned SEL_BIT = LIN_W + EXP_W;

  div_mode_e          mode;
  logic [LIN_W-1:0]   lin_f;
  logic [EXP_W-1:0]   exp_f;
  logic [CNT_W-1:0]   lin_val;
  logic [CNT_W-1:0]   exp_val;
  logic [CNT_W-1:0]   next_val;

  assign mode  = div_mode_e'(ctl[SEL_BIT]);
  assign lin_f = ctl[LIN_W-1:0];
  assign exp_f = ctl[LIN_W +: EXP_W];

  // Linear scheme: half period minus one is the field itself.
  generate
    if (CNT_W > LIN_W) begin : g_lin_pad
      assign lin_val = {{(CNT_W-LIN_W){1'b0}}, lin_f};
    end else begin : g_lin_fit
      assign lin_val = lin_f[CNT_W-1:0];
    end
  endgenerate

  // Exponential scheme: 2^E - 1 is a thermometer of E ones.
  genvar gi;
  generate
    for (gi = 0; gi < CNT_W; gi++) begin : g_therm
      assign exp_val[gi] = (32'(exp_f) > gi);
    end
  endgenerate

  always_comb begin
    case (mode)
      DIV_LIN: next_val = lin_val;
      default: next_val = exp_val;
    endcase
  end

  // The divisor is taken over only while no burst is running.
  always_ff @(posedge clk) begin
    if (rst) begin
      half_m1 <= '0;
    end else if (!hold) begin
      half_m1 <= next_val;
    end
  end
endmodule

// File: rtl/spi_sck_timer.sv
module spi_sck_timer #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] half_m1,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == half_m1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_sck_edge.sv
module spi_sck_edge (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  input  logic idle_pol,
  input  logic pha,
  output logic sck,
  output logic launch_stb,
  output logic sample_stb
);
  logic pha_q;
  logic lead_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck        <= 1'b0;
      pha_q      <= 1'b0;
      lead_next  <= 1'b1;
      launch_stb <= 1'b0;
      sample_stb <= 1'b0;
    end else if (!run) begin
      sck        <= idle_pol;
      pha_q      <= pha;
      lead_next  <= 1'b1;
      launch_stb <= 1'b0;
      sample_stb <= 1'b0;
    end else if (tick) begin
      sck        <= ~sck;
      lead_next  <= ~lead_next;
      sample_stb <= lead_next ^ pha_q;
      launch_stb <= ~(lead_next ^ pha_q);
    end else begin
      launch_stb <= 1'b0;
      sample_stb <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
  import spi_sck_pkg::*;
#(
  parameter int unsigned LIN_W = 8,
  parameter int unsigned EXP_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LIN_W+EXP_W:0] clk_ctl,
  input  logic                 idle_high,
  input  logic                 late_phase,
  input  logic                 burst_on,
  output logic                 sck,
  output logic                 launch_stb,
  output logic                 sample_stb
);
  localparam int unsigned CNT_W = half_cnt_width(LIN_W, EXP_W);

  logic [CNT_W-1:0] half_m1;
  logic             tick;

  spi_sck_cfg #(
    .LIN_W(LIN_W),
    .EXP_W(EXP_W),
    .CNT_W(CNT_W)
  ) cfg_i (
    .clk     (clk),
    .rst     (rst),
    .hold    (burst_on),
    .ctl     (clk_ctl),
    .half_m1 (half_m1)
  );

  spi_sck_timer #(
    .CNT_W(CNT_W)
  ) timer_i (
    .clk     (clk),
    .rst     (rst),
    .run     (burst_on),
    .half_m1 (half_m1),
    .tick    (tick)
  );

  spi_sck_edge edge_i (
    .clk        (clk),
    .rst        (rst),
    .run        (burst_on),
    .tick       (tick),
    .idle_pol   (idle_high),
    .pha        (late_phase),
    .sck        (sck),
    .launch_stb (launch_stb),
    .sample_stb (sample_stb)
  );
endmodule

// File: rtl/spi_sck_gen_chk.sv
module spi_sck_gen_chk #(
  parameter int unsigned CNT_W = 15
) (
  input logic             clk,
  input logic             rst,
  input logic             burst_on,
  input logic             idle_high,
  input logic             sck,
  input logic             launch_stb,
  input logic             sample_stb,
  input logic [CNT_W-1:0] half_m1
);
  // R2
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(burst_on)) |-> (sck == $past(idle_high) && !launch_stb && !sample_stb));

  // R6
  div_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(burst_on)) |-> $stable(half_m1));

  // R8
  strobe_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (launch_stb || sample_stb)) |-> (sck != $past(sck)));

  // R8
  edge_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(burst_on) && (sck != $past(sck))) |-> (launch_stb || sample_stb));

  // R7
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({launch_stb, sample_stb}));
endmodule

bind spi_sck_gen spi_sck_gen_chk #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .burst_on   (burst_on),
  .idle_high  (idle_high),
  .sck        (sck),
  .launch_stb (launch_stb),
  .sample_stb (sample_stb),
  .half_m1    (half_m1)
);

// File: tb/spi_sck_gen_tb_top.sv
`timescale 1ns/1ps
module spi_sck_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] clk_ctl = '0;
  logic        idle_high = 1'b0;
  logic        late_phase = 1'b0;
  logic        burst_on = 1'b0;
  logic        sck, launch_stb, sample_stb;

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_tag = "R1";
  bit    finished = 0;

  // Reference model state
  logic m_sck, m_launch, m_sample, m_pha;
  int   m_half, m_cnt, m_edges;

  always #10 clk = ~clk;

  spi_sck_gen dut_i (
    .clk        (clk),
    .rst        (rst),
    .clk_ctl    (clk_ctl),
    .idle_high  (idle_high),
    .late_phase (late_phase),
    .burst_on   (burst_on),
    .sck        (sck),
    .launch_stb (launch_stb),
    .sample_stb (sample_stb)
  );

  function automatic logic [12:0] lin_word(input int n);
    return {1'b1, 4'h0, 8'(n)};
  endfunction

  function automatic logic [12:0] exp_word(input int e);
    return {1'b0, 4'(e), 8'h00};
  endfunction

  // Behavioural model of the serial clock, written from the requirements.
  always @(posedge clk) begin
    if (rst) begin
      m_sck = 0; m_launch = 0; m_sample = 0; m_pha = 0;
      m_half = 1; m_cnt = 0; m_edges = 0;
    end else if (!burst_on) begin
      m_sck = idle_high; m_launch = 0; m_sample = 0;
      m_pha = late_phase; m_cnt = 0; m_edges = 0;
      if (clk_ctl[12]) m_half = int'(clk_ctl[7:0]) + 1;
      else             m_half = 1 << int'(clk_ctl[11:8]);
    end else begin
      m_launch = 0; m_sample = 0;
      m_cnt++;
      if (m_cnt == m_half) begin
        m_cnt = 0;
        m_sck = !m_sck;
        m_edges++;
        if (((m_edges % 2) == 1) != m_pha) m_sample = 1;
        else                               m_launch = 1;
      end
    end
  end

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Compare against the model on every cycle, away from the active edge.
  always @(negedge clk) begin
    if (!finished) begin
      check(cur_tag, "sck", sck, m_sck);
      check("R8", "launch_stb", launch_stb, m_launch);
      check("R7", "sample_stb", sample_stb, m_sample);
    end
  end

  task automatic burst(input logic [12:0] w, input logic pol, input logic pha,
                       input int n, input string tag);
    @(negedge clk);
    cur_tag = tag;
    clk_ctl = w; idle_high = pol; late_phase = pha; burst_on = 0;
    repeat (3) @(negedge clk);
    burst_on = 1;
    repeat (n) @(negedge clk);
    burst_on = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", "reset sck", sck, 1'b0);
    check("R1", "reset strobes", launch_stb | sample_stb, 1'b0);
    rst = 0;
    @(negedge clk);
    check("R1", "post-reset sck", sck, 1'b0);

    // R2: idle level follows polarity
    idle_high = 1;
    @(negedge clk);
    check("R2", "idle high", sck, 1'b1);
    idle_high = 0;
    @(negedge clk);
    check("R2", "idle low", sck, 1'b0);

    burst(lin_word(0),   1'b0, 1'b0, 20,   "R4");
    burst(lin_word(0),   1'b1, 1'b1, 9,    "R4");
    burst(lin_word(3),   1'b1, 1'b1, 40,   "R3");
    burst(lin_word(3),   1'b0, 1'b1, 33,   "R3");
    burst(lin_word(255), 1'b0, 1'b0, 1600, "R3");
    burst(exp_word(0),   1'b1, 1'b0, 12,   "R5");
    burst(exp_word(2),   1'b0, 1'b1, 50,   "R5");
    burst(exp_word(10),  1'b1, 1'b0, 5000, "R5");

    // R6: settings written mid-burst are ignored until idle
    @(negedge clk);
    cur_tag = "R6";
    clk_ctl = lin_word(2); idle_high = 0; late_phase = 0;
    repeat (3) @(negedge clk);
    burst_on = 1;
    repeat (10) @(negedge clk);
    clk_ctl = exp_word(0); idle_high = 1; late_phase = 1;
    repeat (30) @(negedge clk);
    burst_on = 0;
    @(negedge clk);
    check("R6", "idle after change", sck, 1'b1);
    burst_on = 1;
    repeat (10) @(negedge clk);
    burst_on = 0;
    repeat (2) @(negedge clk);

    // R9: burst dropped partway through a half period
    cur_tag = "R9";
    clk_ctl = lin_word(5); idle_high = 1; late_phase = 0;
    repeat (3) @(negedge clk);
    burst_on = 1;
    repeat (9) @(negedge clk);
    burst_on = 0;
    @(negedge clk);
    check("R9", "abort to idle", sck, 1'b1);
    burst_on = 1;
    repeat (30) @(negedge clk);
    burst_on = 0;
    repeat (3) @(negedge clk);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule